// File: doc/BRIEF.md
# SPI Slave with Global Error Flag

This block is the serial front end of a fault-reporting device. A host exchanges 16-bit frames with it. Each frame holds an address byte and then a data byte. As the address byte goes in, the block returns a status byte. As the data byte goes in, it returns the contents of the addressed register. A single summary bit (the global error flag) appears on the serial output as soon as chip select goes low, before any clock. This lets a host poll for trouble with a frame that has no clock at all. When several slaves are chained, each slave ORs that bit with the bit arriving on its serial input. The output at the end of the chain then carries the flag of every device.

All pins are sampled by a fast system clock through synchronizers. The serial output and its enable are driven directly from the live chip select, the live serial input and registered state, so the first bit needs no clock edge. Fault events arrive as one-cycle pulses and are held in sticky bits. A protocol-error bit joins them. The status returned in a frame is a snapshot taken when the address byte ends. A fault that arrives later in the frame waits for the next frame. Writes to an external register file are committed only at the end of a well-formed frame.

Top module: `spiGefSlave`

## Requirements
- R1: `sdoEn` is low whenever `csN` is high and high whenever `csN` is low.
- R2: While `csN` is low and no `sclk` rising edge has yet occurred in the frame, `sdo` equals the global error flag ORed with `sdi`.
- R3: A pulse on any `faultPulse` bit sets a sticky fault bit. The global error flag is the OR of all sticky fault bits and the protocol-error bit.
- R4: During the first byte, `sdo` returns the status byte {flag, protocol error, faults[5:0]} (bit 7 to bit 0) as it stood when `csN` fell. It is sent MSB first, with `sdi` sampled on `sclk` rising and `sdo` changing on `sclk` falling. The first bit the host samples is the flag ORed with `sdi`.
- R5: The address byte is {write (bit 7), register index (bits 6:1), must-be-one (bit 0)}. During the second byte, `sdo` returns the status snapshot for index 0 and `regRdData` for any other index.
- R6: The status snapshot is taken at the eighth `sclk` rising edge. A fault arriving after that edge does not appear in the current frame and does appear in the next one.
- R7: An address byte with bit 0 equal to 0 sets the sticky protocol-error bit. That frame makes no register access.
- R8: A frame whose clock count is non-zero and not a multiple of 8 sets the protocol-error bit and writes nothing.
- R9: A write is committed on the rising edge of `csN` only after exactly 16 clocks, with bit 0 set, the write bit set and a non-zero index. It appears as a one-cycle `regWrEn` pulse with `regIdx` and `regWrData`.
- R10: A frame with no `sclk` edge changes no state and makes no register access.
- R11: A 16-clock read of index 0 clears, at the end of the frame, exactly the fault and error bits held in its snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in (from the host or the previous slave) |
| faultPulse | input | 6 | One-cycle fault event pulses |
| regRdData | input | 8 | Read data of the external register at `regIdx` |
| sdo | output | 1 | Serial data out |
| sdoEn | output | 1 | Output enable for `sdo` (high-impedance when low) |
| regIdx | output | 6 | Register index of the current or last frame |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Data to write |

## Verification
The hardest case to reach is a fault that arrives inside the narrow window between the end of the address byte and the rise of chip select. The frame driver therefore takes a fault mask and pulses it right after the ninth clock, while the data byte is still shifting. The scoreboard then expects the old snapshot in that frame. It expects the late fault in the next status read and its removal only in the read after that. Frames of 0, 8, 15 and 24 clocks, and address bytes with bit 0 cleared, are driven through the same task to reach the error and no-write paths.

// File: rtl/spiGefPkg.sv
package spiGefPkg;
  // strobes from the frame control to the datapath, all one clk cycle wide
  typedef struct packed {
    logic frameStart;  // chip select seen falling
    logic frameEnd;    // chip select seen rising
    logic sampleBit;   // sclk rising inside a frame
    logic addrDone;    // the rising edge that completes the address byte
    logic shiftBit;    // sclk falling, shift the output byte
    logic loadData;    // sclk falling after the address byte, load data byte
    logic commit;      // frame closed after exactly two bytes
    logic protoErr;    // frame closed after a count that is not whole bytes
  } spiStrb_t;
endpackage

// File: rtl/spiGefCtrl.sv
module spiGefCtrl
  import spiGefPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclk,
  input  logic     csN,
  input  logic     sdi,
  output logic     sdiS,
  output spiStrb_t strb
);
  localparam logic [CNT_W-1:0] BYTE_C = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] FRAME_C = CNT_W'(2 * DATA_W);

  logic [2:0] sclkQ, csQ;
  logic [1:0] sdiQ;
  logic [CNT_W-1:0] cnt;
  logic sclkRise, sclkFall, csLow, csFell, csRose;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= '1;
      sdiQ  <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], sclk};
      csQ   <= {csQ[1:0], csN};
      sdiQ  <= {sdiQ[0], sdi};
    end
  end

  assign sclkRise = sclkQ[1] & ~sclkQ[2];
  assign sclkFall = ~sclkQ[1] & sclkQ[2];
  assign csLow    = ~csQ[1];
  assign csFell   = ~csQ[1] & csQ[2];
  assign csRose   = csQ[1] & ~csQ[2];
  assign sdiS     = sdiQ[1];

  // rising-edge counter, saturating; cleared at both frame boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  cnt <= '0;
    else if (csFell || csRose)                  cnt <= '0;
    else if (csLow && sclkRise && cnt != '1)    cnt <= cnt + 1'b1;
  end

  always_comb begin
    strb            = '0;
    strb.frameStart = csFell;
    strb.frameEnd   = csRose;
    strb.sampleBit  = csLow & sclkRise;
    strb.addrDone   = csLow & sclkRise & (cnt == BYTE_C - 1'b1);
    strb.loadData   = csLow & sclkFall & (cnt == BYTE_C);
    strb.shiftBit   = csLow & sclkFall & (cnt != BYTE_C);
    strb.commit     = csRose & (cnt == FRAME_C);
    strb.protoErr   = csRose & (cnt != '0) & ((cnt % BYTE_C) != '0);
  end

  // R10: outside a frame the counter rests at zero
  p_idle_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    !csLow && !strb.frameEnd |-> cnt == '0);
endmodule

// File: rtl/spiGefDatapath.sv
module spiGefDatapath
  import spiGefPkg::*;
#(
  parameter int FAULT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spiStrb_t             strb,
  input  logic                 sdiS,
  input  logic                 sdiRaw,
  input  logic                 csN,
  input  logic [FAULT_W-1:0]   faultPulse,
  input  logic [FAULT_W+1:0]   regRdData,
  output logic                 sdo,
  output logic                 sdoEn,
  output logic [FAULT_W-1:0]   regIdx,
  output logic                 regWrEn,
  output logic [FAULT_W+1:0]   regWrData
);
  localparam int DATA_W = FAULT_W + 2;
  localparam int ERR_B  = FAULT_W;

  logic [FAULT_W-1:0] faults, clrFaults;
  logic spiErr, clrErr, setErr, gef, preClk;
  logic [DATA_W-1:0] shIn, shOut, addrQ, snap, statusLive, addrNext;
  logic readStatus, doWrite;

  assign gef        = (|faults) | spiErr;
  assign statusLive = {gef, spiErr, faults};
  assign addrNext   = {shIn[DATA_W-2:0], sdiS};
  assign regIdx     = addrQ[DATA_W-2:1];

  assign readStatus = strb.commit & addrQ[0] & ~addrQ[DATA_W-1] & (regIdx == '0);
  assign doWrite    = strb.commit & addrQ[0] & addrQ[DATA_W-1] & (regIdx != '0);
  assign clrFaults  = readStatus ? snap[FAULT_W-1:0] : '0;
  assign clrErr     = readStatus & snap[ERR_B];
  assign setErr     = (strb.addrDone & ~addrNext[0]) | strb.protoErr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faults <= '0;
      spiErr <= 1'b0;
    end else begin
      faults <= (faults & ~clrFaults) | faultPulse;
      spiErr <= setErr | (spiErr & ~clrErr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn   <= '0;
      shOut  <= '0;
      addrQ  <= '0;
      snap   <= '0;
      preClk <= 1'b1;
    end else begin
      if (strb.frameStart)     shIn <= '0;
      else if (strb.sampleBit) shIn <= addrNext;

      if (strb.addrDone) begin
        addrQ <= addrNext;
        snap  <= statusLive;
      end

      if (strb.frameStart)     shOut <= statusLive;
      else if (strb.loadData)  shOut <= (regIdx == '0) ? snap : regRdData;
      else if (strb.shiftBit)  shOut <= {shOut[DATA_W-2:0], 1'b0};

      if (strb.frameStart || strb.frameEnd) preClk <= 1'b1;
      else if (strb.sampleBit)              preClk <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= doWrite;
      if (doWrite) regWrData <= shIn;
    end
  end

  // zero-clock flag path: live flag ORed with the chain input
  assign sdoEn = ~csN;
  assign sdo   = preClk ? (gef | sdiRaw) : shOut[DATA_W-1];

  // R3: a fault event always raises the flag on the next cycle
  p_fault_latch_r3: assert property (@(posedge clk) disable iff (!rstN)
    |faultPulse |=> gef);
  // R7: the error bit only drops at a committed frame end
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    spiErr && !strb.commit |=> spiErr);
  // R9: the write strobe is a single-cycle pulse
  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  // R2: once shifting starts the zero-clock path is released
  p_preclk_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftBit |-> !preClk);
endmodule

// File: rtl/spiGefSlave.sv
module spiGefSlave
  import spiGefPkg::*;
#(
  parameter int FAULT_W = 6,
  parameter int CNT_W   = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclk,
  input  logic                 csN,
  input  logic                 sdi,
  input  logic [FAULT_W-1:0]   faultPulse,
  input  logic [FAULT_W+1:0]   regRdData,
  output logic                 sdo,
  output logic                 sdoEn,
  output logic [FAULT_W-1:0]   regIdx,
  output logic                 regWrEn,
  output logic [FAULT_W+1:0]   regWrData
);
  localparam int DATA_W = FAULT_W + 2;

  spiStrb_t strb;
  logic sdiS;

  spiGefCtrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .sdiS(sdiS), .strb(strb)
  );

  spiGefDatapath #(.FAULT_W(FAULT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdiS(sdiS), .sdiRaw(sdi),
    .csN(csN), .faultPulse(faultPulse), .regRdData(regRdData),
    .sdo(sdo), .sdoEn(sdoEn), .regIdx(regIdx), .regWrEn(regWrEn),
    .regWrData(regWrData)
  );
endmodule

// File: tb/test_spiGefSlave.sv
module test_spiGefSlave;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdi = 1'b0;
  logic [5:0] faultPulse = '0;
  logic [7:0] regRdData, regWrData;
  logic [5:0] regIdx;
  logic sdo, sdoEn, regWrEn;

  always #2 clk = ~clk;  // 250 MHz

  spiGefSlave i_spiGefSlave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .faultPulse(faultPulse), .regRdData(regRdData), .sdo(sdo), .sdoEn(sdoEn),
    .regIdx(regIdx), .regWrEn(regWrEn), .regWrData(regWrData)
  );

  // external register file model
  logic [7:0] regMem [64];
  int wrCount = 0;
  logic [5:0] lastIdx = '0;
  logic [7:0] lastData = '0;
  initial for (int i = 0; i < 64; i++) regMem[i] = '0;
  assign regRdData = regMem[regIdx];
  always @(posedge clk) if (regWrEn) begin
    regMem[regIdx] <= regWrData;
    wrCount  <= wrCount + 1;
    lastIdx  <= regIdx;
    lastData <= regWrData;
  end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [5:0] expFaults = '0;
  logic expErr = 1'b0;

  typedef struct {
    string       req;
    int          cmpBits;
    logic [15:0] val;
    logic        pre;
  } item_t;
  item_t sbq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic expGef();
    return (|expFaults) | expErr;
  endfunction

  function automatic logic [7:0] statusByte();
    return {expGef(), expErr, expFaults};
  endfunction

  task automatic pulseFault(input logic [5:0] m);
    @(negedge clk) faultPulse = m;
    @(negedge clk) faultPulse = '0;
    expFaults |= m;
  endtask

  // driver: pushes the expected item, then runs the frame
  task automatic frame(input string req, input logic [15:0] tx, input int nclk,
                       input logic sdiPre, input int cmpBits, input logic [15:0] expVal,
                       input logic [5:0] lateFault);
    item_t it;
    it.req = req; it.cmpBits = cmpBits; it.val = expVal; it.pre = expGef() | sdiPre;
    sbq.push_back(it);
    @(negedge clk) begin sdi = sdiPre; csN = 1'b0; end
    repeat (8) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? tx[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      if (i == 8 && lateFault != '0) pulseFault(lateFault);
    end
    repeat (8) @(negedge clk);
    csN = 1'b1; sdi = 1'b0;
    repeat (12) @(negedge clk);
    chk("R1 sdoEn idle", {31'd0, sdoEn}, 32'd0);
  endtask

  // monitor: gathers the bits seen by the host and compares with the queue
  initial begin
    logic [15:0] rx, first16;
    logic preBit, enBit;
    int n;
    item_t it;
    forever begin
      @(negedge csN);
      repeat (4) @(posedge clk);
      #1 preBit = sdo; enBit = sdoEn;
      rx = '0; n = 0; first16 = '0;
      while (csN == 1'b0) begin
        @(posedge sclk or posedge csN);
        if (csN == 1'b0) begin
          rx = {rx[14:0], sdo};
          n++;
          if (n == 16) first16 = rx;
        end
      end
      if (n < 16) first16 = rx << (16 - n);
      if (sbq.size() == 0) chk("R4 scoreboard underflow", 32'd1, 32'd0);
      else begin
        it = sbq.pop_front();
        chk({it.req, " R1 sdoEn"}, {31'd0, enBit}, 32'd1);
        chk({it.req, " R2 pre-clock bit"}, {31'd0, preBit}, {31'd0, it.pre});
        if (it.cmpBits == 16) chk({it.req, " frame bits"}, {16'd0, first16}, {16'd0, it.val});
        else if (it.cmpBits == 8) chk({it.req, " first byte"}, {24'd0, first16[15:8]}, {24'd0, it.val[15:8]});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset sdoEn", {31'd0, sdoEn}, 32'd0);
    chk("R9 reset regWrEn", {31'd0, regWrEn}, 32'd0);

    // R4 R5: clean status read
    frame("R4 clean status read", 16'h0100, 16, 1'b0, 16, 16'h0000, '0);
    // R2: zero-clock frames, chain input alone
    frame("R2 chain one", 16'h0000, 0, 1'b1, 0, 16'h0000, '0);
    frame("R2 chain zero", 16'h0000, 0, 1'b0, 0, 16'h0000, '0);

    // R3: own fault raises flag with zero clocks; R10: state kept
    pulseFault(6'b000100);
    frame("R3 own flag", 16'h0000, 0, 1'b0, 0, 16'h0000, '0);
    frame("R10 zero-clock keeps state", 16'h0000, 0, 1'b0, 0, 16'h0000, '0);
    chk("R10 no write on zero-clock", wrCount, 0);

    // R6 R11: late fault deferred; read clears only snapped bits
    s = statusByte();
    frame("R6 snapshot read", 16'h0100, 16, 1'b0, 16, {s, s}, 6'b100000);
    expFaults = 6'b100000;
    s = statusByte();
    chk("R6 late fault pending", {24'd0, s}, 32'h0A0);
    frame("R6 deferred fault shown", 16'h0100, 16, 1'b0, 16, {s, s}, '0);
    expFaults = '0;
    frame("R11 cleared", 16'h0100, 16, 1'b0, 16, 16'h0000, '0);

    // R9: good write
    frame("R9 write idx5", 16'h8BA5, 16, 1'b0, 16, 16'h8000, '0);
    chk("R9 write count", wrCount, 1);
    chk("R9 write idx", {26'd0, lastIdx}, 32'd5);
    chk("R9 write data", {24'd0, lastData}, 32'hA5);
    // R5: read back other register
    frame("R5 read idx5", 16'h0B00, 16, 1'b0, 16, 16'h00A5, '0);

    // R9: 24 clocks, whole bytes, no write and no error
    frame("R9 24-clock write", 16'h8B3C, 24, 1'b0, 16, 16'h80A5, '0);
    chk("R9 no write on 24 clocks", wrCount, 1);
    frame("R8 no error on 24 clocks", 16'h0100, 16, 1'b0, 16, 16'h0000, '0);

    // R8: 15 clocks -> error, no write
    frame("R8 15-clock write", 16'h8B3C, 15, 1'b0, 8, 16'h8000, '0);
    expErr = 1'b1;
    chk("R8 no write on 15 clocks", wrCount, 1);
    frame("R8 error read", 16'h0100, 16, 1'b0, 16, 16'hC0C0, '0);
    expErr = 1'b0;

    // R7: address bit 0 clear, 8 clocks
    frame("R7 bad address 8 clocks", 16'h0A00, 8, 1'b0, 8, 16'h0000, '0);
    expErr = 1'b1;
    frame("R7 error sticky zero-clock", 16'h0000, 0, 1'b0, 0, 16'h0000, '0);
    frame("R7 error read", 16'h0100, 16, 1'b0, 16, 16'hC0C0, '0);
    expErr = 1'b0;

    // R7 R9: 16-clock write with bad address is refused
    frame("R7 bad address write", 16'h8AFF, 16, 1'b0, 16, 16'h80A5, '0);
    expErr = 1'b1;
    chk("R7 no write on bad address", wrCount, 1);
    chk("R7 register untouched", {24'd0, regMem[5]}, 32'hA5);
    frame("R11 error read clears", 16'h0100, 16, 1'b0, 16, 16'hC0C0, '0);
    expErr = 1'b0;
    frame("R11 after clear", 16'h0100, 16, 1'b0, 16, 16'h0000, '0);

    repeat (20) @(negedge clk);
    chk("R4 scoreboard drained", sbq.size(), 0);
    finishRun();
  end
endmodule